// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Posted Stores

This block sits between a processor and a slower main memory. It holds 8192 bytes of copies in 256 lines of 32 bytes, and each line position can hold one memory line. On a read it looks at the one line picked by the address and checks that line's stored tag and valid flag. A hit is answered one cycle later. A miss fetches the whole line from memory in one wide transfer, installs it and answers with the requested word.

Every accepted store goes to memory, so memory never lags the cache. Stores are placed in a four-entry queue, which lets the processor continue while earlier stores drain. A store that hits also merges its enabled bytes into the cached word in the cycle it is accepted. A store that misses leaves the cache untouched. Since queued stores may target the line a read miss is about to fetch, the fetch is held back until the queue is empty.

All three channels use valid/ready handshakes. A transfer happens on a rising edge where both valid and ready are high. Once a source raises valid, it keeps valid and its payload steady until the transfer. The processor request sees `cpu_req_ready` low while a miss is in progress, and for stores while the queue is full. The read response and the memory line return are single-cycle pulses with no back-pressure.

Top module: `wt_cache`

## Requirements
- R1: After reset every line is invalid, no response is pending, neither memory channel is valid and `cpu_req_ready` is high, so the first read of any address misses.
- R2: A request address splits as tag = bits 31:13, line index = bits 12:5, word-in-line = bits 4:2. Bits 1:0 are ignored. A line fetch carries address bits 31:5 on `mem_rd_addr`.
- R3: A read that hits raises `cpu_rsp_valid` for exactly the cycle after the accepting edge, with the stored word, and starts no memory line read.
- R4: A read miss fetches one line and installs it with word w taken from `mem_rd_rsp_data` bits 32w+31:32w. It answers with the requested word. Later reads of other words of that line hit.
- R5: Two addresses with the same index and different tags evict each other, so alternating reads of them always miss.
- R6: Every accepted store appears exactly once on the word-write channel, in acceptance order. It carries address bits 31:2, its byte enables (bit b covers data bits 8b+7:8b) and its data.
- R7: A store that hits replaces only the enabled bytes of the cached word, and the next read of that word returns the merged value without a memory read.
- R8: A store that misses does not install the line, so a later read of that address still fetches from memory.
- R9: The store queue holds four entries. With four stores pending, a store request is refused (`cpu_req_ready` low) while read hits are still served.
- R10: A read miss does not raise `mem_rd_valid` while any store is still queued. All stores accepted before the miss reach memory before the line read.
- R11: While `mem_rd_valid` or `mem_wr_valid` is high without ready, it stays high and its payload is unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request can be taken this cycle |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_be | input | 4 | Store byte enables |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Memory takes the line read |
| mem_rd_addr | output | 27 | Line address (byte address bits 31:5) |
| mem_rd_rsp_valid | input | 1 | Line data returned (one-cycle pulse) |
| mem_rd_rsp_data | input | 256 | Returned line, word 0 in the low bits |
| mem_wr_valid | output | 1 | Queued store at head |
| mem_wr_ready | input | 1 | Memory takes the store |
| mem_wr_addr | output | 30 | Word address (byte address bits 31:2) |
| mem_wr_be | output | 4 | Store byte enables |
| mem_wr_data | output | 32 | Store data |

## Verification
Reads are driven as a cold miss, a hit to another word of the same line with nonzero low address bits, and alternating reads of two addresses that share an index. These separate correct tag and index slicing from wrong slicing, and show that byte offsets are ignored. Partial-byte stores to a cached word, followed by a read, separate a byte merge from a whole-word overwrite. A store to an uncached address, followed by a read, separates no-allocate from allocate. With the memory write channel stalled, four stores fill the queue and then a fifth store and a read miss are offered. This shows the fifth store being refused and the line fetch waiting for the queued stores to drain. A stalled line-read handshake shows that the request is held.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int WTC_WORD_W = 32;
  localparam int WTC_BE_W   = WTC_WORD_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FETCH = 2'd2,
    ST_WAIT  = 2'd3
  } wtc_state_e;
endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf
  import wtc_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int DEPTH   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [WADDR_W-1:0]    push_addr,
  input  logic [WTC_BE_W-1:0]   push_be,
  input  logic [WTC_WORD_W-1:0] push_data,
  output logic                  full,
  output logic                  empty,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WADDR_W-1:0]    out_addr,
  output logic [WTC_BE_W-1:0]   out_be,
  output logic [WTC_WORD_W-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WADDR_W-1:0]    addr_q [DEPTH];
  logic [WTC_BE_W-1:0]   be_q   [DEPTH];
  logic [WTC_WORD_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]      wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  pop;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign out_valid = !empty;
  assign pop       = out_valid && out_ready;
  assign out_addr  = addr_q[rd_ptr_q];
  assign out_be    = be_q[rd_ptr_q];
  assign out_data  = data_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      be_q[wr_ptr_q]   <= push_be;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9: the request side never pushes into a full queue
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R11: a stalled store stays offered with the same payload
  a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                   $stable(out_be) && $stable(out_data)));
endmodule

// File: rtl/wtc_store.sv
module wtc_store
  import wtc_pkg::*;
#(
  parameter int LINES = 256,
  parameter int WORDS = 8,
  parameter int TAG_W = 19
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(LINES)-1:0]    rd_idx,
  input  logic [$clog2(WORDS)-1:0]    rd_word,
  output logic [TAG_W-1:0]            rd_tag,
  output logic                        rd_valid,
  output logic [WTC_WORD_W-1:0]       rd_data,
  input  logic                        wr_en,
  input  logic [$clog2(LINES)-1:0]    wr_idx,
  input  logic [$clog2(WORDS)-1:0]    wr_word,
  input  logic [WTC_BE_W-1:0]         wr_be,
  input  logic [WTC_WORD_W-1:0]       wr_data,
  input  logic                        fill_en,
  input  logic [$clog2(LINES)-1:0]    fill_idx,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic [WORDS*WTC_WORD_W-1:0] fill_line
);
  logic [WTC_WORD_W-1:0] data_q [LINES][WORDS];
  logic [TAG_W-1:0]      tag_q  [LINES];
  logic [LINES-1:0]      valid_q;

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_data  = data_q[rd_idx][rd_word];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_tag;
      for (int w = 0; w < WORDS; w++) begin
        data_q[fill_idx][w] <= fill_line[w*WTC_WORD_W +: WTC_WORD_W];
      end
    end else if (wr_en) begin
      for (int b = 0; b < WTC_BE_W; b++) begin
        if (wr_be[b]) data_q[wr_idx][wr_word][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  // R8: a line install never coincides with a store merge
  a_r8_fill_excl: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !wr_en);
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_we,
  input  logic hit,
  input  logic wb_full,
  input  logic wb_empty,
  input  logic mem_rd_ready,
  input  logic mem_rsp_valid,
  output logic req_ready,
  output logic rd_hit_acc,
  output logic miss_acc,
  output logic wr_acc,
  output logic mem_rd_valid,
  output logic fill_en
);
  wtc_state_e state_q, state_d;
  logic       acc;

  assign req_ready    = (state_q == ST_IDLE) && !(req_we && wb_full);
  assign acc          = req_valid && req_ready;
  assign rd_hit_acc   = acc && !req_we && hit;
  assign miss_acc     = acc && !req_we && !hit;
  assign wr_acc       = acc && req_we;
  assign mem_rd_valid = (state_q == ST_FETCH);
  assign fill_en      = (state_q == ST_WAIT) && mem_rsp_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (miss_acc)      state_d = ST_DRAIN;
      ST_DRAIN: if (wb_empty)      state_d = ST_FETCH;
      ST_FETCH: if (mem_rd_ready)  state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R10: a line read is only offered once the store queue is empty
  a_r10_fetch_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> wb_empty);
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_BYTES  = 32,
  parameter int WB_DEPTH    = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cpu_req_valid,
  output logic                                  cpu_req_ready,
  input  logic                                  cpu_req_we,
  input  logic [ADDR_W-1:0]                     cpu_req_addr,
  input  logic [WTC_BE_W-1:0]                   cpu_req_be,
  input  logic [WTC_WORD_W-1:0]                 cpu_req_wdata,
  output logic                                  cpu_rsp_valid,
  output logic [WTC_WORD_W-1:0]                 cpu_rsp_rdata,
  output logic                                  mem_rd_valid,
  input  logic                                  mem_rd_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  mem_rd_addr,
  input  logic                                  mem_rd_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]               mem_rd_rsp_data,
  output logic                                  mem_wr_valid,
  input  logic                                  mem_wr_ready,
  output logic [ADDR_W-$clog2(WTC_BE_W)-1:0]    mem_wr_addr,
  output logic [WTC_BE_W-1:0]                   mem_wr_be,
  output logic [WTC_WORD_W-1:0]                 mem_wr_data
);
  localparam int WORDS   = LINE_BYTES / WTC_BE_W;
  localparam int LINES   = CACHE_BYTES / LINE_BYTES;
  localparam int BYTE_W  = $clog2(WTC_BE_W);
  localparam int WSEL_W  = $clog2(WORDS);
  localparam int OFF_W   = BYTE_W + WSEL_W;
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int WADDR_W = ADDR_W - BYTE_W;

  // request address fields
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic              byte_off_unused;

  assign req_tag         = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx         = cpu_req_addr[OFF_W +: IDX_W];
  assign req_word        = cpu_req_addr[BYTE_W +: WSEL_W];
  assign byte_off_unused = ^cpu_req_addr[BYTE_W-1:0];

  logic [TAG_W-1:0]      st_tag;
  logic                  st_valid;
  logic [WTC_WORD_W-1:0] st_data;
  logic                  hit;
  logic                  rd_hit_acc, miss_acc, wr_acc, fill_en;
  logic                  wb_full, wb_empty;

  assign hit = st_valid && (st_tag == req_tag);

  // outstanding miss
  logic [LADDR_W-1:0] miss_laddr_q;
  logic [WSEL_W-1:0]  miss_word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_laddr_q <= '0;
      miss_word_q  <= '0;
    end else if (miss_acc) begin
      miss_laddr_q <= cpu_req_addr[ADDR_W-1:OFF_W];
      miss_word_q  <= req_word;
    end
  end

  assign mem_rd_addr = miss_laddr_q;

  // processor response
  logic                  rsp_valid_q;
  logic [WTC_WORD_W-1:0] rsp_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rd_hit_acc || fill_en;
      if (rd_hit_acc)   rsp_data_q <= st_data;
      else if (fill_en) rsp_data_q <= mem_rd_rsp_data[miss_word_q*WTC_WORD_W +: WTC_WORD_W];
    end
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;

  wtc_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (cpu_req_valid),
    .req_we        (cpu_req_we),
    .hit           (hit),
    .wb_full       (wb_full),
    .wb_empty      (wb_empty),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rsp_valid (mem_rd_rsp_valid),
    .req_ready     (cpu_req_ready),
    .rd_hit_acc    (rd_hit_acc),
    .miss_acc      (miss_acc),
    .wr_acc        (wr_acc),
    .mem_rd_valid  (mem_rd_valid),
    .fill_en       (fill_en)
  );

  wtc_store #(
    .LINES (LINES),
    .WORDS (WORDS),
    .TAG_W (TAG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (req_idx),
    .rd_word   (req_word),
    .rd_tag    (st_tag),
    .rd_valid  (st_valid),
    .rd_data   (st_data),
    .wr_en     (wr_acc && hit),
    .wr_idx    (req_idx),
    .wr_word   (req_word),
    .wr_be     (cpu_req_be),
    .wr_data   (cpu_req_wdata),
    .fill_en   (fill_en),
    .fill_idx  (miss_laddr_q[IDX_W-1:0]),
    .fill_tag  (miss_laddr_q[LADDR_W-1 -: TAG_W]),
    .fill_line (mem_rd_rsp_data)
  );

  wtc_wbuf #(
    .WADDR_W (WADDR_W),
    .DEPTH   (WB_DEPTH)
  ) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_acc),
    .push_addr (cpu_req_addr[ADDR_W-1:BYTE_W]),
    .push_be   (cpu_req_be),
    .push_data (cpu_req_wdata),
    .full      (wb_full),
    .empty     (wb_empty),
    .out_valid (mem_wr_valid),
    .out_ready (mem_wr_ready),
    .out_addr  (mem_wr_addr),
    .out_be    (mem_wr_be),
    .out_data  (mem_wr_data)
  );

  // R11: a stalled line read keeps its request and address
  a_r11_rd_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

// File: tb/tb_wt_cache.sv
module tb_wt_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_ready;
  logic         cpu_req_we = 1'b0;
  logic [31:0]  cpu_req_addr = '0;
  logic [3:0]   cpu_req_be = '0;
  logic [31:0]  cpu_req_wdata = '0;
  logic         cpu_rsp_valid;
  logic [31:0]  cpu_rsp_rdata;
  logic         mem_rd_valid;
  logic         mem_rd_ready;
  logic [26:0]  mem_rd_addr;
  logic         mem_rd_rsp_valid = 1'b0;
  logic [255:0] mem_rd_rsp_data = '0;
  logic         mem_wr_valid;
  logic         mem_wr_ready;
  logic [29:0]  mem_wr_addr;
  logic [3:0]   mem_wr_be;
  logic [31:0]  mem_wr_data;

  logic rd_ready_en = 1'b1;
  logic wr_ready_en = 1'b1;
  assign mem_rd_ready = rd_ready_en;
  assign mem_wr_ready = wr_ready_en;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wt_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_be(cpu_req_be), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_rsp_valid(mem_rd_rsp_valid),
    .mem_rd_rsp_data(mem_rd_rsp_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_be(mem_wr_be), .mem_wr_data(mem_wr_data)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem_q [logic [29:0]];
  logic [29:0] wl_addr [64];
  logic [3:0]  wl_be   [64];
  logic [31:0] wl_data [64];
  int          wl_n = 0;
  int          n_rd = 0;
  int          wl_at_rd = 0;
  logic [26:0] last_rd_la = '0;
  int          rd_cnt = 0;

  function automatic logic [31:0] pat(input logic [29:0] wa);
    return {wa, 2'b00} ^ 32'hC3A5_5A3C;
  endfunction

  function automatic logic [31:0] mem_word(input logic [29:0] wa);
    if (mem_q.exists(wa)) return mem_q[wa];
    return pat(wa);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = old_w;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    mem_rd_rsp_valid <= 1'b0;
    if (rd_cnt != 0) begin
      rd_cnt <= rd_cnt - 1;
      if (rd_cnt == 1) begin
        mem_rd_rsp_valid <= 1'b1;
        for (int w = 0; w < 8; w++)
          mem_rd_rsp_data[w*32 +: 32] <= mem_word({last_rd_la, 3'(w)});
      end
    end
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      mem_q[mem_wr_addr] = merge(mem_word(mem_wr_addr), mem_wr_data, mem_wr_be);
      if (wl_n < 64) begin
        wl_addr[wl_n] = mem_wr_addr;
        wl_be[wl_n]   = mem_wr_be;
        wl_data[wl_n] = mem_wr_data;
      end
      wl_n = wl_n + 1;
    end
    if (rst_n && mem_rd_valid && mem_rd_ready) begin
      rd_cnt     <= 3;
      last_rd_la <= mem_rd_addr;
      n_rd        = n_rd + 1;
      wl_at_rd    = wl_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_read(input logic [31:0] a, output logic [31:0] d, output int lat);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = a; cpu_req_be = '0;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 1;
    while (!cpu_rsp_valid && lat < 500) begin @(negedge clk); lat++; end
    d = cpu_rsp_rdata;
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = a;
    cpu_req_be = be; cpu_req_wdata = wd;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_we = 1'b0;
  endtask

  task automatic wait_drained(input int n);
    int g = 0;
    while (wl_n < n && g < 500) begin @(negedge clk); g++; end
  endtask

  localparam logic [31:0] A = 32'h0000_1040;
  localparam logic [31:0] B = 32'h0000_3040;
  localparam logic [31:0] C = 32'h0004_0100;
  localparam logic [31:0] D = 32'h0008_0000;

  // ---------------- scenarios ----------------
  task automatic t_reset;
    @(negedge clk);
    check("R1 ready after reset", 64'(cpu_req_ready), 64'd1);
    check("R1 no response after reset", 64'(cpu_rsp_valid), 64'd0);
    check("R1 memory channels idle", 64'({mem_rd_valid, mem_wr_valid}), 64'd0);
  endtask

  task automatic t_cold_miss;
    logic [31:0] d; int lat; int r0;
    r0 = n_rd;
    cpu_read(A, d, lat);
    check("R1 first read misses", 64'(n_rd - r0), 64'd1);
    check("R2 line address", 64'(last_rd_la), 64'(A >> 5));
    check("R4 miss data", 64'(d), 64'(pat(A >> 2)));
  endtask

  task automatic t_hit_other_word;
    logic [31:0] d; int lat; int r0;
    r0 = n_rd;
    cpu_read(A + 32'h1F, d, lat);
    check("R3 hit latency", 64'(lat), 64'd1);
    check("R3 hit no memory read", 64'(n_rd - r0), 64'd0);
    check("R2 byte offset ignored, word 7", 64'(d), 64'(pat((A + 32'h1C) >> 2)));
  endtask

  task automatic t_conflict;
    logic [31:0] d; int lat; int r0;
    r0 = n_rd;
    cpu_read(B, d, lat);
    check("R5 conflicting tag misses", 64'(n_rd - r0), 64'd1);
    check("R5 conflict data", 64'(d), 64'(pat(B >> 2)));
    cpu_read(A, d, lat);
    check("R5 evicted line misses again", 64'(n_rd - r0), 64'd2);
  endtask

  task automatic t_write_hit;
    logic [31:0] d; int lat; int r0; logic [31:0] expw;
    expw = merge(pat((A + 4) >> 2), 32'hDEAD_BEEF, 4'b0101);
    cpu_write(A + 4, 4'b0101, 32'hDEAD_BEEF);
    wait_drained(1);
    check("R6 store reached memory", 64'(wl_n), 64'd1);
    check("R6 store address", 64'(wl_addr[0]), 64'((A + 4) >> 2));
    check("R6 store enables and data", 64'({wl_be[0], wl_data[0]}), {28'd0, 4'b0101, 32'hDEAD_BEEF});
    r0 = n_rd;
    cpu_read(A + 4, d, lat);
    check("R7 merged read is a hit", 64'(n_rd - r0), 64'd0);
    check("R7 byte merge", 64'(d), 64'(expw));
  endtask

  task automatic t_write_miss;
    logic [31:0] d; int lat; int r0; int g;
    cpu_write(C, 4'b1111, 32'h1234_5678);
    wait_drained(2);
    r0 = n_rd;
    rd_ready_en = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = C;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 line read held while stalled", 64'(mem_rd_valid), 64'd1);
    check("R11 held line address", 64'(mem_rd_addr), 64'(C >> 5));
    rd_ready_en = 1'b1;
    g = 0;
    while (!cpu_rsp_valid && g < 500) begin @(negedge clk); g++; end
    d = cpu_rsp_rdata;
    check("R8 write miss did not allocate", 64'(n_rd - r0), 64'd1);
    check("R8 read sees stored word", 64'(d), 64'h1234_5678);
  endtask

  task automatic t_queue_full;
    logic [31:0] d; int lat; int g; logic [31:0] rdy;
    wr_ready_en = 1'b0;
    for (int i = 0; i < 4; i++) cpu_write(A + 8 + 4*i, 4'b1111, 32'hA000_0000 + i);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = A + 24;
    cpu_req_be = 4'b1111; cpu_req_wdata = 32'h5555_5555;
    #1;
    rdy = 32'(cpu_req_ready);
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_we = 1'b0;
    check("R9 fifth store refused", 64'(rdy), 64'd0);
    cpu_read(A + 8, d, lat);
    check("R9 read hit served while full", 64'(lat), 64'd1);
    check("R7 full-word store hit", 64'(d), 64'hA000_0000);
    // read miss while stores are queued
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = D;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    g = 0;
    for (int i = 0; i < 8; i++) begin
      if (mem_rd_valid) g++;
      @(negedge clk);
    end
    check("R10 no line read while stores queued", 64'(g), 64'd0);
    wr_ready_en = 1'b1;
    g = 0;
    while (!cpu_rsp_valid && g < 500) begin @(negedge clk); g++; end
    check("R10 stores drained before line read", 64'(wl_at_rd), 64'd6);
    check("R4 miss data after drain", 64'(cpu_rsp_rdata), 64'(pat(D >> 2)));
    for (int i = 0; i < 4; i++)
      check("R6 store order", 64'(wl_addr[2+i]), 64'((A + 8 + 4*i) >> 2));
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold_miss();
    t_hit_other_word();
    t_conflict();
    t_write_hit();
    t_write_miss();
    t_queue_full();
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule